// File: doc/BRIEF.md
# Up-Counting Timer with Compare

This block is a general-purpose timer that sits on a simple 32-bit register bus. It has an address, a write strobe, write data and a read-data return that is combinational. A 16-bit prescaler divides the input clock into counting ticks. On each tick the counter moves up by one. When it reaches its reload limit, it returns to zero and raises an update event. One compare register is matched against the counter to mark a deadline. The timer raises a level interrupt when an update flag or a compare flag is set and the matching enable bit is on.

The counter width is a parameter, normally 16 or 32. The counter, reload and compare registers store only that many bits, so software can find the width by writing all ones and reading the value back. Software can force an update event by writing to the event register. This reloads the counter and commits pending prescaler and reload values. An update-disable bit lets the counter keep wrapping without raising update events. A one-pulse bit stops the counter after its first wrap.

Top module: `ucount_timer`

## Requirements
- R1: After reset every register reads zero, the counter is stopped and `irq` is low.
- R2: The registers sit at these byte addresses: control 0x00, interrupt enable 0x0C, status 0x10, event 0x14, counter 0x24, prescaler 0x28, reload 0x2C, compare 0x34. In control, bit 0 runs the counter, bit 1 is update-disable, bit 3 is one-pulse and bit 7 is reload buffering. While bit 0 is clear the counter holds its value.
- R3: The counter advances once every (active prescaler + 1) clocks. A value written to the prescaler register becomes active only at the next update event.
- R4: On a tick where the counter equals the active limit, the counter becomes zero and status bit 0 (update flag) is set.
- R5: While update-disable is set, a wrap still zeroes the counter but does not set the update flag and does not load the prescaler or reload shadows.
- R6: While one-pulse is set, a wrap also clears control bit 0, and the counter then stays at zero.
- R7: With control bit 7 set, the limit is a shadow copy of the reload register that is loaded at each update event. With bit 7 clear, the reload register is the limit at once.
- R8: On a tick where the counter equals the compare register, status bit 1 (compare flag) is set.
- R9: `irq` is high exactly when some status flag is set and its enable bit is set (interrupt-enable bit 0 for update, bit 1 for compare). Writing zero to interrupt enable drives `irq` low.
- R10: A status write clears each flag whose data bit is 0 and leaves the flag unchanged where the data bit is 1. A flag set by hardware in the same cycle stays set.
- R11: Writing 1 to event bit 0 zeroes the counter and the prescaler count, loads both shadows and sets the update flag. The event register reads zero.
- R12: Counter, reload and compare store only the counter width and prescaler stores 16 bits. Bits that are not stored and unmapped addresses read as zero, and writes to them are ignored.
- R13: Software can write the counter register directly, and that write takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The in-module assertions check the following on every clock:
- the counter steps by one on each non-limit tick;
- a wrap lands on zero;
- a stopped counter holds;
- the active prescaler changes only on an update event;
- update-disable keeps the update flag quiet;
- one-pulse clears the run bit;
- a compare hit leaves the compare flag set.

Only the bench scenarios can show the following:
- a new prescaler value arrives late, with the tick spacing changing only after the following wrap;
- a buffered reload limit is deferred while an unbuffered one takes effect at once;
- register values read back truncated;
- interrupt masking follows the enable register;
- the status write-zero-to-clear rule holds.

// File: rtl/ucount_timer.sv
module ucount_timer #(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'('h24);
  localparam logic [ADDR_W-1:0] A_PSC  = ADDR_W'('h28);
  localparam logic [ADDR_W-1:0] A_RLD  = ADDR_W'('h2C);
  localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'('h34);

  logic run, upd_off, one_pulse, rld_buf;
  logic [1:0] ien, sts;
  logic [PSC_W-1:0] psc_pre, psc_act, pcnt;
  logic [CNT_W-1:0] cnt, rld_pre, rld_act, cmp, limit, cnt_inc;

  logic wr_ctrl, wr_ien, wr_sts, wr_evt, wr_cnt, wr_psc, wr_rld, wr_cmp;
  logic force_upd, tick, at_lim, wrap, nat_upd, upd_ev, cmp_hit;
  logic unused_wbits;

  assign wr_ctrl = bus_we && bus_addr == A_CTRL;
  assign wr_ien  = bus_we && bus_addr == A_IEN;
  assign wr_sts  = bus_we && bus_addr == A_STS;
  assign wr_evt  = bus_we && bus_addr == A_EVT;
  assign wr_cnt  = bus_we && bus_addr == A_CNT;
  assign wr_psc  = bus_we && bus_addr == A_PSC;
  assign wr_rld  = bus_we && bus_addr == A_RLD;
  assign wr_cmp  = bus_we && bus_addr == A_CMP;
  assign unused_wbits = ^bus_wdata;

  assign force_upd = wr_evt && bus_wdata[0];
  assign tick      = run && (pcnt == psc_act);
  assign limit     = rld_buf ? rld_act : rld_pre;
  assign at_lim    = (cnt == limit);
  assign wrap      = tick && at_lim;
  assign nat_upd   = wrap && !upd_off;
  assign upd_ev    = force_upd || nat_upd;
  assign cmp_hit   = tick && (cnt == cmp);
  assign cnt_inc   = cnt + 1'b1;
  assign irq       = |(sts & ien);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (force_upd || tick) begin
      pcnt <= '0;
    end else if (run) begin
      pcnt <= pcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (wr_cnt) begin
      cnt <= bus_wdata[CNT_W-1:0];
    end else if (force_upd) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= at_lim ? '0 : cnt_inc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psc_act <= '0;
      rld_act <= '0;
    end else if (upd_ev) begin
      psc_act <= psc_pre;
      rld_act <= rld_pre;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run       <= 1'b0;
      upd_off   <= 1'b0;
      one_pulse <= 1'b0;
      rld_buf   <= 1'b0;
    end else if (wr_ctrl) begin
      run       <= bus_wdata[0];
      upd_off   <= bus_wdata[1];
      one_pulse <= bus_wdata[3];
      rld_buf   <= bus_wdata[7];
    end else if (wrap && one_pulse) begin
      run <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien     <= '0;
      psc_pre <= '0;
      rld_pre <= '0;
      cmp     <= '0;
    end else begin
      if (wr_ien) ien     <= bus_wdata[1:0];
      if (wr_psc) psc_pre <= bus_wdata[PSC_W-1:0];
      if (wr_rld) rld_pre <= bus_wdata[CNT_W-1:0];
      if (wr_cmp) cmp     <= bus_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts <= '0;
    end else begin
      sts <= ((wr_sts ? (sts & bus_wdata[1:0]) : sts)) | {cmp_hit, upd_ev};
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata[7:0] = {rld_buf, 3'b000, one_pulse, 1'b0, upd_off, run};
      A_IEN:  bus_rdata[1:0] = ien;
      A_STS:  bus_rdata[1:0] = sts;
      A_CNT:  bus_rdata[CNT_W-1:0] = cnt;
      A_PSC:  bus_rdata[PSC_W-1:0] = psc_pre;
      A_RLD:  bus_rdata[CNT_W-1:0] = rld_pre;
      A_CMP:  bus_rdata[CNT_W-1:0] = cmp;
      default: bus_rdata = '0;
    endcase
  end

  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !wr_cnt) |=> (cnt == '0));

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !at_lim && !wr_cnt && !force_upd) |=> (cnt == $past(cnt_inc)));

  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt && !force_upd) |=> $stable(cnt));

  p_psc_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_ev) |=> $stable(psc_act));

  p_upd_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && upd_off && !force_upd && !sts[0]) |=> !sts[0]);

  p_one_pulse_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && one_pulse && !wr_ctrl) |=> !run);

  p_cmp_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit |=> sts[1]);

endmodule

// File: tb/ucount_timer_tb_top.sv
`timescale 1ns/100ps
module ucount_timer_tb_top;
  localparam logic [7:0] A_CTRL = 8'h00, A_IEN = 8'h0C, A_STS = 8'h10, A_EVT = 8'h14;
  localparam logic [7:0] A_CNT = 8'h24, A_PSC = 8'h28, A_RLD = 8'h2C, A_CMP = 8'h34;
  localparam int NV = 12;
  localparam logic [71:0] VEC [NV] = '{
    {A_CTRL, 32'hFFFF_FFFE, 32'h0000_008A},
    {A_CTRL, 32'h0000_0000, 32'h0000_0000},
    {A_IEN,  32'hFFFF_FFFF, 32'h0000_0003},
    {A_IEN,  32'h0000_0000, 32'h0000_0000},
    {A_PSC,  32'hFFFF_FFFF, 32'h0000_FFFF},
    {A_PSC,  32'h0001_2345, 32'h0000_2345},
    {A_RLD,  32'hFFFF_FFFF, 32'h0000_FFFF},
    {A_RLD,  32'h0001_0005, 32'h0000_0005},
    {A_CMP,  32'h000A_BCDE, 32'h0000_BCDE},
    {A_CNT,  32'h1234_5678, 32'h0000_5678},
    {8'h18,  32'hFFFF_FFFF, 32'h0000_0000},
    {A_STS,  32'hFFFF_FFFF, 32'h0000_0000}
  };

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, irq;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  ucount_timer dut_i (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
                      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #0.5;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    errors++; checks++;
    $display("FAIL watchdog R1..R13 actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    // R1 reset state
    rdchk("R1 counter", A_CNT, 0);
    rdchk("R1 control", A_CTRL, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R12 R13 R2 register table
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rdchk("R12 table readback", VEC[i][71:64], VEC[i][31:0]);
    end

    // R4 count and wrap, prescale 0
    wr(A_PSC, 0); wr(A_EVT, 1); wr(A_STS, 0);
    wr(A_RLD, 3); wr(A_CMP, 100); wr(A_CNT, 0); wr(A_CTRL, 1);
    wait_n(2); rdchk("R4 count up", A_CNT, 2);
    wait_n(2); rdchk("R4 wrap to zero", A_CNT, 0);
    rdchk("R4 update flag", A_STS, 1);
    wr(A_CTRL, 0);
    wait_n(3); rdchk("R2 stopped holds", A_CNT, 1);

    // R9 irq gating, R10 status clear rule
    chk("R9 masked", {31'b0, irq}, 0);
    wr(A_IEN, 1); chk("R9 update irq", {31'b0, irq}, 1);
    wr(A_IEN, 2); chk("R9 other enable", {31'b0, irq}, 0);
    wr(A_STS, 1); rdchk("R10 write one keeps", A_STS, 1);
    wr(A_STS, 32'hFFFF_FFFE); rdchk("R10 write zero clears", A_STS, 0);
    wr(A_IEN, 0);

    // R3 prescaler pending until update
    wr(A_PSC, 2); wr(A_CNT, 0); wr(A_CTRL, 1);
    wait_n(2); rdchk("R3 old prescale still active", A_CNT, 2);
    wait_n(2); rdchk("R3 wrap", A_CNT, 0);
    wait_n(2); rdchk("R3 divided hold", A_CNT, 0);
    wait_n(1); rdchk("R3 divided step", A_CNT, 1);
    wr(A_CTRL, 0);

    // R11 forced update
    wr(A_PSC, 0); wr(A_STS, 0); wr(A_EVT, 1);
    rdchk("R11 counter zeroed", A_CNT, 0);
    rdchk("R11 flag set", A_STS, 1);
    rdchk("R11 event reads zero", A_EVT, 0);

    // R5 update-disable
    wr(A_STS, 0); wr(A_CTRL, 3);
    wait_n(3); rdchk("R5 counting", A_CNT, 3);
    wait_n(1); rdchk("R5 wrapped", A_CNT, 0);
    rdchk("R5 no flag", A_STS, 0);
    wr(A_CTRL, 0);

    // R6 one-pulse
    wr(A_CNT, 0); wr(A_STS, 0); wr(A_CTRL, 9);
    wait_n(4); rdchk("R6 wrapped", A_CNT, 0);
    rdchk("R6 run cleared", A_CTRL, 8);
    rdchk("R6 flag", A_STS, 1);
    wait_n(2); rdchk("R6 stays zero", A_CNT, 0);

    // R8 compare
    wr(A_CMP, 2); wr(A_STS, 0); wr(A_CTRL, 1);
    wait_n(2); rdchk("R8 before match", A_STS, 0);
    wait_n(1); rdchk("R8 compare flag", A_STS, 2);
    wr(A_IEN, 2); chk("R9 compare irq", {31'b0, irq}, 1);
    wr(A_CTRL, 0);
    wr(A_IEN, 0); chk("R9 zero enable masks", {31'b0, irq}, 0);

    // R7 buffered reload
    wr(A_STS, 0); wr(A_CNT, 0); wr(A_CTRL, 32'h80); wr(A_RLD, 6); wr(A_CTRL, 32'h81);
    wait_n(3); rdchk("R7 old limit reached", A_CNT, 3);
    wait_n(1); rdchk("R7 old limit wrap", A_CNT, 0);
    wait_n(6); rdchk("R7 new limit reached", A_CNT, 6);
    wait_n(1); rdchk("R7 new limit wrap", A_CNT, 0);
    wr(A_CTRL, 0);
    wr(A_CNT, 0); wr(A_RLD, 2); wr(A_CTRL, 1);
    wait_n(2); rdchk("R7 unbuffered reach", A_CNT, 2);
    wait_n(1); rdchk("R7 unbuffered wrap", A_CNT, 0);
    wr(A_CTRL, 0);

    // R13 write wins over counting
    wr(A_CTRL, 1); wr(A_CNT, 32'h0000_0040);
    rdchk("R13 direct write", A_CNT, 32'h40);
    wr(A_CTRL, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule